// File: doc/BRIEF.md
# Prescaled Compare-Match Interval Timer

This block is a free-standing interval timer. A prescale divider turns the timer clock into a count tick, and each tick advances an up-counter. When the counter reaches a programmed compare value, the block raises a match flag. That flag drives an interrupt line, and it can also raise a wake request. Four operating modes set what happens at a match: the timer stops, reloads, reloads and toggles an output, or keeps running and wraps. Software programs and watches the timer through a small word-wide register port.

The control sits in a two-state machine with the states `ST_IDLE` and `ST_COUNT`. Its transitions are:

- **start**: a control write with the run bit set moves `ST_IDLE` to `ST_COUNT`.
- **pause**: a control write with the run bit clear moves `ST_COUNT` to `ST_IDLE`. The count is kept.
- **soft reset**: a control write with the reset bit set, made in `ST_COUNT`, moves to `ST_IDLE` and zeroes the count and the prescaler.
- **one-shot end**: a match in one-shot mode moves to `ST_IDLE`.

If a start or pause write arrives in the same cycle as a one-shot match, the write wins.

Rewriting the compare value while counting follows a policy bit. Either the counter restarts, or it keeps running when the new target still lies ahead of it.

Top module: `interval_timer`

## Requirements
- R1: With prescale field P, the counter advances once every P+1 clocks while running. From a zeroed counter, the first match comes compare×(P+1) clocks after the start write.
- R2: The match flag is status bit 0. It is set in the cycle the counter reaches the compare value. In periodic mode (mode 01) the counter then reloads to 0 and counts again.
- R3: Status bit 0 (match) and bit 1 (wake) are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R4: `irq` is high exactly while the match flag and the interrupt enable (control bit 9) are both 1.
- R5: A control write with bit 15 set while the timer is active clears the counter, the prescaler and the run state. While idle, such a write has no effect on the count.
- R6: Control bit 16 reads 1 while the counter is running and 0 otherwise. Control bit 8 (run) reads the same state.
- R7: The data register (address 3) loads the live count each clock only while control bit 14 is 1. Otherwise it holds its value.
- R8: Policy bit 13 applies in one-shot and periodic modes. When it is 0, every compare write (address 1) restarts the count. When it is 1, the count keeps running if the new compare value is greater than the count, and restarts otherwise.
- R9: With wake enable (control bit 10) set, a match sets status bit 1 and asserts `wake_req`.
- R10: In one-shot mode (mode 00) the run state clears at the match, and the counter rests at 0.
- R11: In toggle mode (mode 10) the counter reloads at each match and `tgl_out` inverts.
- R12: In continuous mode (mode 11) a match sets the flag but the counter keeps counting and wraps at 2^24.
- R13: Compare values 0 and 1 are stored and used as 2.
- R14: Clearing the run bit freezes the counter and the prescaler. Restarting continues from the frozen values.

The control register holds prescale in bits [7:0] and mode in bits [12:11]. The status register is at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 compare, 2 status, 3 data (read only) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request |
| tgl_out | output | 1 | Toggle-mode output |

## Verification
The bench builds the timer with its default widths: an 8-bit prescaler, a 24-bit counter and a 32-bit register word. It then uses small compare values and prescale settings of 0 and 3, so that every mode reaches several matches within a few hundred clocks. Those small compare values also make the clamp of 0 and 1 observable. Policy tests rewrite the compare value at a known count of 10, which places the value-above and value-below cases for the restart policy at exact cycle distances.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    typedef enum logic [1:0] {
        MODE_ONESHOT    = 2'b00,
        MODE_PERIODIC   = 2'b01,
        MODE_TOGGLE     = 2'b10,
        MODE_CONTINUOUS = 2'b11
    } tmode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } tstate_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_CMP    = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;
    localparam logic [1:0] ADDR_DATA   = 2'd3;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;

    assign tick = en && !clear && (pre_cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_cnt <= '0;
        else if (clear)  pre_cnt <= '0;
        else if (tick)   pre_cnt <= '0;
        else if (en)     pre_cnt <= pre_cnt + 1'b1;
    end

    // R1: after a tick the divider restarts its interval
    assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pre_cnt == '0);
    // R14: a stopped divider keeps its value
    assert_freeze_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> $stable(pre_cnt));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  tmode_e           mode,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [CNT_W-1:0] next_cnt;

    assign next_cnt = count + 1'b1;
    assign hit      = tick && !clear && (next_cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        count <= '0;
        else if (clear)    count <= '0;
        else if (tick) begin
            if (hit && mode != MODE_CONTINUOUS) count <= '0;
            else                                count <= next_cnt;
        end
    end

    // R2: a match outside continuous mode reloads the counter
    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode != MODE_CONTINUOUS) |=> count == '0);
    // R12: continuous mode counts through the match
    assert_no_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == MODE_CONTINUOUS) |=> count == $past(next_cnt));
    // R14: no tick and no clear means no movement
    assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(count));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              wake_req,
    output logic              tgl_out
);
    localparam int B_RUN   = PRE_W;
    localparam int B_IE    = PRE_W + 1;
    localparam int B_WAKE  = PRE_W + 2;
    localparam int B_MODE  = PRE_W + 3;
    localparam int B_KEEP  = PRE_W + 5;
    localparam int B_LOAD  = PRE_W + 6;
    localparam int B_SRST  = PRE_W + 7;
    localparam int B_ACT   = PRE_W + 8;
    localparam logic [CNT_W-1:0] CMP_MIN = CNT_W'(2);

    tstate_e          state_q, state_d;
    logic [PRE_W-1:0] presc_q;
    logic             ie_q, wake_en_q, keep_q, load_q;
    tmode_e           mode_q;
    logic [CNT_W-1:0] cmp_q, cmp_new, count, data_q;
    logic             match_q, wakef_q, tgl_q;
    logic             active, ctrl_wr, cmp_wr, st_wr, soft_rst, cmp_restart;
    logic             clr, tick, hit;

    assign active   = (state_q == ST_COUNT);
    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign cmp_wr   = wr_en && (wr_addr == ADDR_CMP);
    assign st_wr    = wr_en && (wr_addr == ADDR_STATUS);
    assign soft_rst = ctrl_wr && wr_data[B_SRST] && active;
    assign cmp_new  = (wr_data[CNT_W-1:0] < CMP_MIN) ? CMP_MIN : wr_data[CNT_W-1:0];
    assign cmp_restart = cmp_wr
                       && (mode_q == MODE_ONESHOT || mode_q == MODE_PERIODIC)
                       && (!keep_q || cmp_new <= count);
    assign clr      = soft_rst || cmp_restart;

    itmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(active), .clear(clr),
        .limit(presc_q), .tick(tick)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clr),
        .mode(mode_q), .cmp(cmp_q), .count(count), .hit(hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && wr_data[B_RUN]) state_d = ST_COUNT;           // start
            end
            ST_COUNT: begin
                if (soft_rst)                              state_d = ST_IDLE; // soft reset
                else if (ctrl_wr && !wr_data[B_RUN])       state_d = ST_IDLE; // pause
                else if (!ctrl_wr && hit && mode_q == MODE_ONESHOT)
                                                           state_d = ST_IDLE; // one-shot end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q   <= '0;
            ie_q      <= 1'b0;
            wake_en_q <= 1'b0;
            mode_q    <= MODE_ONESHOT;
            keep_q    <= 1'b0;
            load_q    <= 1'b0;
            cmp_q     <= CMP_MIN;
            match_q   <= 1'b0;
            wakef_q   <= 1'b0;
            tgl_q     <= 1'b0;
            data_q    <= '0;
        end else begin
            if (ctrl_wr) begin
                presc_q   <= wr_data[PRE_W-1:0];
                ie_q      <= wr_data[B_IE];
                wake_en_q <= wr_data[B_WAKE];
                mode_q    <= tmode_e'(wr_data[B_MODE +: 2]);
                keep_q    <= wr_data[B_KEEP];
                load_q    <= wr_data[B_LOAD];
            end
            if (cmp_wr) cmp_q <= cmp_new;
            match_q <= (match_q && !(st_wr && wr_data[0])) || hit;
            wakef_q <= (wakef_q && !(st_wr && wr_data[1])) || (hit && wake_en_q);
            if (hit && mode_q == MODE_TOGGLE) tgl_q <= !tgl_q;
            if (load_q) data_q <= count;
        end
    end

    assign irq      = match_q && ie_q;
    assign wake_req = wakef_q;
    assign tgl_out  = tgl_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[PRE_W-1:0]     = presc_q;
                rd_data[B_RUN]         = active;
                rd_data[B_IE]          = ie_q;
                rd_data[B_WAKE]        = wake_en_q;
                rd_data[B_MODE +: 2]   = mode_q;
                rd_data[B_KEEP]        = keep_q;
                rd_data[B_LOAD]        = load_q;
                rd_data[B_ACT]         = active;
            end
            ADDR_CMP:    rd_data[CNT_W-1:0] = cmp_q;
            ADDR_STATUS: rd_data[1:0]       = {wakef_q, match_q};
            default:     rd_data[CNT_W-1:0] = data_q;
        endcase
    end

    // R4: an enabled match raises the interrupt on the next cycle
    assert_irq_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ie_q && !ctrl_wr) |=> irq);
    // R9: an enabled match raises the wake request
    assert_wake_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wake_en_q) |=> wake_req);
    // R10: one-shot match stops the timer
    assert_oneshot_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q == MODE_ONESHOT && !ctrl_wr) |=> !active);
    // R13: a written compare value is never below the minimum
    assert_cmp_clamp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> cmp_q >= CMP_MIN);
    // R5: soft reset while active leaves the timer idle
    assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!active && count == '0));
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RUN  = 32'h0000_0100;
    localparam logic [31:0] IE   = 32'h0000_0200;
    localparam logic [31:0] WKE  = 32'h0000_0400;
    localparam logic [31:0] KEEP = 32'h0000_2000;
    localparam logic [31:0] LOAD = 32'h0000_4000;
    localparam logic [31:0] SRST = 32'h0000_8000;
    localparam logic [31:0] M_ONE = 32'h0000_0000;
    localparam logic [31:0] M_PER = 32'h0000_0800;
    localparam logic [31:0] M_TGL = 32'h0000_1000;
    localparam logic [31:0] M_CON = 32'h0000_1800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, wake_req, tgl_out;
    int          errors = 0;
    int          checks = 0;
    int          cycles = 0;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .wake_req(wake_req), .tgl_out(tgl_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_match(output int n);
        n = 0;
        rd_addr = 2'd2;
        #1;
        while (rd_data[0] !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
            #1;
        end
    endtask

    task automatic setup(input logic [31:0] cfg, input logic [31:0] cmp);
        wr(2'd0, M_PER);
        wr(2'd1, cmp);
        wr(2'd2, 32'h3);
        wr(2'd0, cfg | RUN);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); chk("R6 reset ctrl", d, 32'h0);
        rd(2'd2, d); chk("R3 reset status", d, 32'h0);
        rd(2'd1, d); chk("R13 reset compare", d, 32'h2);
        chk("R4 reset irq", {31'b0, irq}, 32'h0);
        chk("R9 reset wake", {31'b0, wake_req}, 32'h0);
    endtask

    task automatic t_periodic;
        int n;
        logic [31:0] d;
        setup(M_PER | IE | LOAD, 32'd5);
        rd(2'd0, d); chk("R6 active bit running", {31'b0, d[16]}, 32'h1);
        wait_match(n);
        chk("R2 first periodic match", n, 5);
        chk("R4 irq with enable", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0);
        rd(2'd2, d); chk("R3 zero write keeps flag", {31'b0, d[0]}, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, d); chk("R3 one write clears flag", {31'b0, d[0]}, 32'h0);
        // the two writes took two ticks of the reloaded count
        wait_match(n);
        chk("R2 reload and repeat", n, 3);
    endtask

    task automatic t_prescale;
        int n;
        setup(32'h3 | M_PER, 32'd4);
        wait_match(n);
        chk("R1 prescale 3 compare 4", n, 16);
        chk("R4 no irq without enable", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h3 | M_PER | RUN | IE);
        chk("R4 irq after enable", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_oneshot;
        int n;
        logic [31:0] d;
        setup(M_ONE | LOAD, 32'd6);
        wait_match(n);
        chk("R10 one-shot match time", n, 6);
        rd(2'd0, d);
        chk("R10 run cleared", {31'b0, d[8]}, 32'h0);
        chk("R6 inactive after one-shot", {31'b0, d[16]}, 32'h0);
        wait_cycles(10);
        rd(2'd3, d); chk("R10 counter rests at 0", d, 32'h0);
    endtask

    task automatic t_toggle;
        int n;
        logic t0;
        setup(M_TGL, 32'd3);
        t0 = tgl_out;
        wait_match(n);
        chk("R11 toggle first match", n, 3);
        chk("R11 output inverted", {31'b0, tgl_out}, {31'b0, ~t0});
        wr(2'd2, 32'h1);
        wait_match(n);
        chk("R11 toggle second period", n, 2);
        chk("R11 output back", {31'b0, tgl_out}, {31'b0, t0});
    endtask

    task automatic t_continuous;
        int n;
        logic [31:0] d;
        setup(M_CON | LOAD, 32'd3);
        wait_match(n);
        chk("R12 continuous match", n, 3);
        wait_cycles(2);
        rd(2'd3, d); chk("R12 counts past compare", d, 32'd4);
    endtask

    task automatic t_clamp;
        int n;
        logic [31:0] d;
        wr(2'd0, M_PER);
        wr(2'd1, 32'd1);
        rd(2'd1, d); chk("R13 compare 1 reads 2", d, 32'd2);
        wr(2'd1, 32'd0);
        rd(2'd1, d); chk("R13 compare 0 reads 2", d, 32'd2);
        wr(2'd2, 32'h3);
        wr(2'd0, M_PER | RUN);
        wait_match(n);
        chk("R13 clamped period", n, 2);
    endtask

    task automatic t_policy(input logic [31:0] pol, input logic [31:0] newc,
                            input int exp_n, input string req);
        int n;
        setup(M_PER | pol, 32'd100);
        wait_cycles(10);
        wr(2'd1, newc);
        wait_match(n);
        chk(req, n, exp_n);
    endtask

    task automatic t_softreset_pause;
        logic [31:0] d;
        setup(M_PER | LOAD, 32'd100);
        wait_cycles(10);
        wr(2'd0, M_PER | LOAD | RUN | SRST);
        rd(2'd0, d); chk("R5 soft reset stops", {31'b0, d[16]}, 32'h0);
        wait_cycles(1);
        rd(2'd3, d); chk("R5 soft reset zeroes count", d, 32'h0);
        setup(M_PER | LOAD, 32'd100);
        wait_cycles(10);
        wr(2'd0, M_PER | LOAD);
        wait_cycles(20);
        rd(2'd3, d); chk("R14 pause freezes count", d, 32'd11);
        wr(2'd0, M_PER | LOAD | SRST);
        wait_cycles(2);
        rd(2'd3, d); chk("R5 idle soft reset ignored", d, 32'd11);
        wr(2'd0, M_PER | LOAD | RUN);
        wait_cycles(3);
        rd(2'd3, d); chk("R14 resume from frozen value", d, 32'd13);
    endtask

    task automatic t_load_gate;
        logic [31:0] d;
        setup(M_PER | LOAD, 32'd1000);
        wait_cycles(5);
        wr(2'd0, M_PER | RUN);
        wait_cycles(10);
        rd(2'd3, d); chk("R7 data holds without load enable", d, 32'd5);
    endtask

    task automatic t_wake;
        int n;
        logic [31:0] d;
        setup(M_PER | WKE, 32'd4);
        wait_match(n);
        chk("R9 wake match time", n, 4);
        chk("R9 wake request", {31'b0, wake_req}, 32'h1);
        rd(2'd2, d); chk("R9 wake flag set", d, 32'h3);
        wr(2'd0, M_PER);
        wr(2'd2, 32'h2);
        chk("R3 wake cleared", {31'b0, wake_req}, 32'h0);
        rd(2'd2, d); chk("R3 match kept", d, 32'h1);
    endtask

    initial begin
        wait (cycles >= 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_periodic();
        t_prescale();
        t_oneshot();
        t_toggle();
        t_continuous();
        t_clamp();
        t_policy(32'h0, 32'd200, 200, "R8 policy 0 restarts");
        t_policy(KEEP, 32'd50, 39, "R8 policy 1 keeps running");
        t_policy(KEEP, 32'd5, 5, "R8 policy 1 restarts below count");
        t_softreset_pause();
        t_load_gate();
        t_wake();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule